// File: doc/BRIEF.md
# ACPI Sleep State Decoder

This block derives the current system sleep state that drives wake-up and power control. In internal mode the host writes a sleep-type code and then pulses a sleep-enable strobe. The block captures the code and looks it up in six software-programmed encoding entries, one for each internal state S0 to S5. It then folds the matching internal state into one of three current states: S12 (fully active), S3I (suspend, main supply optional) and S45 (main supply off).

In external mode, which takes effect only when two separate enable bits are both set, the block ignores the strobe path. It follows two level inputs driven by an external power controller instead. These inputs are disregarded for a programmable qualification time after standby power comes up, so that supply ramps cannot select a wrong state. A legacy power-button override forces S45 whenever the main supply is on and the button input is held low. Besides the current state, the block drives a main-supply-on request.

Top module: `sleep_state_decoder`

## Requirements
- R1: While reset is asserted and directly after it, `cur_state_o` reads S45 and `main_on_o` is 0. The state encoding is 2'b00 = S12, 2'b01 = S3I, 2'b10 = S45, and 2'b11 never appears.
- R2: The sleep-type code is captured only on the cycle `slp_en_i` is sampled high. The lookup acts once, and the new state is visible after the second rising edge counted from that sample. A code change without a strobe leaves the state unchanged.
- R3: `enc_codes_i[3n+2:3n]` holds the code for internal state Sn (n = 0..5). When several entries hold the captured code, the lowest n wins. When no entry matches, the state is held.
- R4: Internal states S0, S1 and S2 fold to S12, S3 folds to S3I, and S5 folds to S45.
- R5: Internal state S4 folds to S3I when `s4_light_i` is 1, and to S45 when it is 0.
- R6: `main_on_o` is 1 in S12 and 0 in S45. In S3I it equals `s3i_main_on_i`.
- R7: External mode is active only when `ext_en_a_i` and `ext_en_b_i` are both 1. In external mode a strobe has no effect on the state. With only one enable set, the strobe path works normally.
- R8: In external mode, after qualification, the synchronized pair (`sleep_lvl3_i`, `sleep_lvl5_i`) maps (1,1) to S12, (0,1) to S3I and (0,0) to S45.
- R9: In external mode the reserved pair (1,0) holds the current state.
- R10: For the first QUAL_CYCLES clock cycles after reset release, the external inputs are ignored and the state is held.
- R11: When `legacy_btn_en_i` and `main_pwr_good_i` are 1 and the synchronized `pwr_btn_n_i` is 0, the state goes to S45. This takes priority over both the external and the strobe paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, standby domain |
| rst_n | input | 1 | Asynchronous active-low reset (standby power-on) |
| slp_typ_i | input | CODE_W | Sleep-type code written by the host |
| slp_en_i | input | 1 | One-cycle sleep-enable strobe |
| enc_codes_i | input | 6*CODE_W | Six encoding entries; entry n at bits [CODE_W*n +: CODE_W] |
| s4_light_i | input | 1 | 1: S4 folds to S3I; 0: S4 folds to S45 |
| s3i_main_on_i | input | 1 | Main-supply request while in S3I |
| ext_en_a_i | input | 1 | First external-mode enable |
| ext_en_b_i | input | 1 | Second external-mode enable |
| sleep_lvl3_i | input | 1 | External suspend level input (asynchronous) |
| sleep_lvl5_i | input | 1 | External soft-off level input (asynchronous) |
| legacy_btn_en_i | input | 1 | Enables the legacy power-button override |
| main_pwr_good_i | input | 1 | Main supply is on |
| pwr_btn_n_i | input | 1 | Power-button level, active low (asynchronous) |
| cur_state_o | output | 2 | Current sleep state (00 S12, 01 S3I, 10 S45) |
| main_on_o | output | 1 | Main-supply-on request |

## Verification
The bench builds the block with QUAL_CYCLES = 40 and SYNC_STAGES = 2, and keeps the default 3-bit code. The short qualification window lets the bench probe the held state just before the window closes and the pin-driven state just after it. The 3-bit code lets it sweep all eight codes under every combination of the S4 select and the S3I supply bit, including codes that match no entry. Duplicate-code tables, every external pin pair and the button override are each visited in turn from a known prior state.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  localparam int NUM_INT = 6;

  typedef enum logic [1:0] {
    CS_S12 = 2'b00,
    CS_S3I = 2'b01,
    CS_S45 = 2'b10
  } cur_state_e;

endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam int CHAIN_W = STAGES * WIDTH;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[CHAIN_W-WIDTH-1:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/sleep_qual_timer.sv
module sleep_qual_timer #(
  parameter int unsigned LIMIT = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);

  localparam int            CW  = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign done   = (cnt_q == LIM);
  assign cnt_en = !done;

  always_comb cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sleep_code_match.sv
module sleep_code_match #(
  parameter int CODE_W  = 3,
  parameter int NUM_ENT = 6,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic [CODE_W-1:0]         code,
  input  logic [NUM_ENT*CODE_W-1:0] table_i,
  output logic                      hit,
  output logic [IDX_W-1:0]          idx
);

  logic [NUM_ENT-1:0] eq;

  generate
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
      assign eq[g] = (table_i[g*CODE_W +: CODE_W] == code);
    end
  endgenerate

  assign hit = |eq;

  // Scan from the top so the lowest matching entry is written last.
  always_comb begin
    idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/sleep_state_fold.sv
module sleep_state_fold
  import sleep_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] int_idx,
  input  logic             s4_light,
  output cur_state_e       st
);

  always_comb begin
    case (int_idx)
      IDX_W'(0), IDX_W'(1), IDX_W'(2): st = CS_S12;
      IDX_W'(3):                       st = CS_S3I;
      IDX_W'(4):                       st = s4_light ? CS_S3I : CS_S45;
      default:                         st = CS_S45;
    endcase
  end

endmodule

// File: rtl/sleep_state_decoder.sv
module sleep_state_decoder
  import sleep_pkg::*;
#(
  parameter int          CODE_W      = 3,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned QUAL_CYCLES = 50_000_000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CODE_W-1:0]         slp_typ_i,
  input  logic                      slp_en_i,
  input  logic [NUM_INT*CODE_W-1:0] enc_codes_i,
  input  logic                      s4_light_i,
  input  logic                      s3i_main_on_i,
  input  logic                      ext_en_a_i,
  input  logic                      ext_en_b_i,
  input  logic                      sleep_lvl3_i,
  input  logic                      sleep_lvl5_i,
  input  logic                      legacy_btn_en_i,
  input  logic                      main_pwr_good_i,
  input  logic                      pwr_btn_n_i,
  output logic [1:0]                cur_state_o,
  output logic                      main_on_o
);

  localparam int IDX_W = $clog2(NUM_INT);

  // Strobe capture stage
  logic              go_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) go_q <= 1'b0;
    else        go_q <= slp_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        code_q <= '0;
    else if (slp_en_i) code_q <= slp_typ_i;
  end

  // Code lookup and fold
  logic             hit;
  logic [IDX_W-1:0] int_idx;
  cur_state_e       folded;

  sleep_code_match #(
    .CODE_W (CODE_W),
    .NUM_ENT(NUM_INT),
    .IDX_W  (IDX_W)
  ) u_match (
    .code   (code_q),
    .table_i(enc_codes_i),
    .hit    (hit),
    .idx    (int_idx)
  );

  sleep_state_fold #(
    .IDX_W(IDX_W)
  ) u_fold (
    .int_idx (int_idx),
    .s4_light(s4_light_i),
    .st      (folded)
  );

  // Asynchronous level inputs
  logic [1:0] pins_s;
  logic       btn_s;

  sleep_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_pin_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sleep_lvl3_i, sleep_lvl5_i}),
    .q    (pins_s)
  );

  sleep_sync #(
    .WIDTH  (1),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_btn_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pwr_btn_n_i),
    .q    (btn_s)
  );

  // Standby power-on qualification
  logic qual_done;

  sleep_qual_timer #(
    .LIMIT(QUAL_CYCLES)
  ) u_qual (
    .clk  (clk),
    .rst_n(rst_n),
    .done (qual_done)
  );

  // Next-state selection
  logic       ext_mode;
  logic       force_off;
  logic       pin_ok;
  cur_state_e pin_state;
  cur_state_e state_q;
  cur_state_e state_d;

  assign ext_mode  = ext_en_a_i & ext_en_b_i;
  assign force_off = legacy_btn_en_i & main_pwr_good_i & ~btn_s;

  always_comb begin
    pin_ok    = 1'b1;
    pin_state = CS_S45;
    case (pins_s)
      2'b11:   pin_state = CS_S12;
      2'b01:   pin_state = CS_S3I;
      2'b00:   pin_state = CS_S45;
      default: pin_ok    = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (force_off) begin
      state_d = CS_S45;
    end else if (ext_mode) begin
      if (qual_done && pin_ok) state_d = pin_state;
    end else if (go_q && hit) begin
      state_d = folded;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CS_S45;
    else        state_q <= state_d;
  end

  // Outputs
  always_comb begin
    case (state_q)
      CS_S12:  main_on_o = 1'b1;
      CS_S3I:  main_on_o = s3i_main_on_i;
      default: main_on_o = 1'b0;
    endcase
  end

  assign cur_state_o = state_q;

endmodule

// File: rtl/sleep_state_decoder_chk.sv
module sleep_state_decoder_chk
  import sleep_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cur_state,
  input logic       main_on,
  input logic       s3i_cfg,
  input logic       legacy_en,
  input logic       pwr_good,
  input logic       btn_s,
  input logic       ext_mode,
  input logic       qual_done,
  input logic [1:0] pins_s,
  input logic       go_q
);

  logic forced;
  assign forced = legacy_en && pwr_good && !btn_s;

  p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cur_state != 2'b11);

  p_s12_supply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == CS_S12) |-> main_on);

  p_s45_supply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == CS_S45) |-> !main_on);

  p_s3i_supply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == CS_S3I) |-> (main_on == s3i_cfg));

  p_btn_force_r11: assert property (@(posedge clk) disable iff (!rst_n)
    forced |=> (cur_state == CS_S45));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!forced && !ext_mode && !go_q) |=> $stable(cur_state));

  p_prequal_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!forced && ext_mode && !qual_done) |=> $stable(cur_state));

  p_reserved_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!forced && ext_mode && pins_s == 2'b10) |=> $stable(cur_state));

endmodule

bind sleep_state_decoder sleep_state_decoder_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cur_state(cur_state_o),
  .main_on  (main_on_o),
  .s3i_cfg  (s3i_main_on_i),
  .legacy_en(legacy_btn_en_i),
  .pwr_good (main_pwr_good_i),
  .btn_s    (btn_s),
  .ext_mode (ext_mode),
  .qual_done(qual_done),
  .pins_s   (pins_s),
  .go_q     (go_q)
);

// File: tb/test_sleep_state_decoder.sv
module test_sleep_state_decoder;

  localparam int CW   = 3;
  localparam int QUAL = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] slp_typ;
  logic          slp_en;
  logic [17:0]   enc;
  logic          s4_light, s3i_on, ext_a, ext_b, lvl3, lvl5;
  logic          legacy_en, pwr_good, btn_n;
  logic [1:0]    cur_state;
  logic          main_on;

  int errors = 0;
  int checks = 0;
  logic [1:0] exp_st;
  bit finished = 0;

  always #10 clk = ~clk;

  sleep_state_decoder #(
    .CODE_W     (CW),
    .SYNC_STAGES(2),
    .QUAL_CYCLES(QUAL)
  ) i_sleep_state_decoder (
    .clk            (clk),
    .rst_n          (rst_n),
    .slp_typ_i      (slp_typ),
    .slp_en_i       (slp_en),
    .enc_codes_i    (enc),
    .s4_light_i     (s4_light),
    .s3i_main_on_i  (s3i_on),
    .ext_en_a_i     (ext_a),
    .ext_en_b_i     (ext_b),
    .sleep_lvl3_i   (lvl3),
    .sleep_lvl5_i   (lvl5),
    .legacy_btn_en_i(legacy_en),
    .main_pwr_good_i(pwr_good),
    .pwr_btn_n_i    (btn_n),
    .cur_state_o    (cur_state),
    .main_on_o      (main_on)
  );

  function automatic logic supply_of(input logic [1:0] st, input logic cfg);
    if (st == 2'b00) return 1'b1;
    if (st == 2'b01) return cfg;
    return 1'b0;
  endfunction

  // Reference lookup: lowest matching entry, fold, or keep prev on no match.
  function automatic logic [1:0] model_int(input logic [CW-1:0] code, input logic [17:0] tbl,
                                           input logic s4, input logic [1:0] prev);
    for (int n = 0; n < 6; n++) begin
      if (tbl[3*n +: 3] == code) begin
        if (n <= 2) return 2'b00;
        if (n == 3) return 2'b01;
        if (n == 4) return s4 ? 2'b01 : 2'b10;
        return 2'b10;
      end
    end
    return prev;
  endfunction

  task automatic check(input logic [1:0] exp, input string req);
    checks++;
    if (cur_state !== exp) begin
      errors++;
      $display("FAIL %s state: actual=%b expected=%b", req, cur_state, exp);
    end
    checks++;
    if (main_on !== supply_of(exp, s3i_on)) begin
      errors++;
      $display("FAIL %s main_on: actual=%b expected=%b", req, main_on, supply_of(exp, s3i_on));
    end
  endtask

  task automatic pulse(input logic [CW-1:0] code);
    @(negedge clk);
    slp_typ = code;
    slp_en  = 1'b1;
    @(negedge clk);
    slp_en  = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic set_pins(input logic a, input logic b);
    lvl3 = a;
    lvl5 = b;
    settle();
  endtask

  initial begin
    rst_n = 1'b0; slp_typ = '0; slp_en = 1'b0; s4_light = 1'b0; s3i_on = 1'b0;
    ext_a = 1'b0; ext_b = 1'b0; lvl3 = 1'b1; lvl5 = 1'b1;
    legacy_en = 1'b0; pwr_good = 1'b0; btn_n = 1'b1;
    for (int n = 0; n < 6; n++) enc[3*n +: 3] = 3'(n + 2);
    repeat (3) @(negedge clk);
    check(2'b10, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(2'b10, "R1 after reset");

    // Qualification window: external mode on, pins ask for S12.
    ext_a = 1'b1; ext_b = 1'b1;
    repeat (34) @(negedge clk);
    check(2'b10, "R10 pins ignored before qualification");
    repeat (15) @(negedge clk);
    exp_st = 2'b00;
    check(exp_st, "R8 pins (1,1) after qualification");

    // External pin sweep, with reserved pair visited from each state.
    s3i_on = 1'b1;
    set_pins(1'b1, 1'b0); check(exp_st, "R9 reserved hold S12");
    set_pins(1'b0, 1'b1); exp_st = 2'b01; check(exp_st, "R8 pins (0,1)");
    set_pins(1'b1, 1'b0); check(exp_st, "R9 reserved hold S3I");
    set_pins(1'b0, 1'b0); exp_st = 2'b10; check(exp_st, "R8 pins (0,0)");
    set_pins(1'b1, 1'b0); check(exp_st, "R9 reserved hold S45");
    set_pins(1'b0, 1'b1); exp_st = 2'b01; check(exp_st, "R8 pins (0,1) again");

    // R7: strobe ignored in external mode (entry 0 code 2 would give S12).
    pulse(3'd2);
    check(exp_st, "R7 strobe ignored in external mode");

    // R7: one enable alone leaves the strobe path in charge.
    ext_b = 1'b0;
    settle();
    check(exp_st, "R7 single enable holds state");
    pulse(3'd2); exp_st = 2'b00;
    check(exp_st, "R7 strobe works with one enable");

    // Exhaustive code sweep: R3 R4 R5 R6 (codes 0 and 1 match nothing).
    for (int s4 = 0; s4 < 2; s4++) begin
      for (int cfg = 0; cfg < 2; cfg++) begin
        for (int c = 0; c < 8; c++) begin
          s4_light = s4[0];
          s3i_on   = cfg[0];
          pulse(3'(c));
          exp_st = model_int(3'(c), enc, s4_light, exp_st);
          check(exp_st, "R3 R4 R5 R6 code sweep");
        end
      end
    end

    // R3: duplicates, lowest index wins. Entries: 0:4 1:4 2:0 3:2 4:2 5:2.
    s4_light = 1'b0;
    enc = {3'd2, 3'd2, 3'd2, 3'd0, 3'd4, 3'd4};
    pulse(3'd2); exp_st = 2'b01; check(exp_st, "R3 duplicate picks S3");
    pulse(3'd4); exp_st = 2'b00; check(exp_st, "R3 duplicate picks S0");
    pulse(3'd7); check(exp_st, "R3 no match holds");

    // R2: code change without strobe.
    slp_typ = 3'd2;
    settle();
    check(exp_st, "R2 code without strobe holds");

    // R11: legacy button override.
    legacy_en = 1'b1; pwr_good = 1'b1; btn_n = 1'b1;
    settle(); check(exp_st, "R11 button released no effect");
    btn_n = 1'b0; settle(); exp_st = 2'b10;
    check(exp_st, "R11 button low forces S45");
    btn_n = 1'b1; settle(); check(exp_st, "R11 release holds S45");
    pulse(3'd4); exp_st = 2'b00; check(exp_st, "R11 strobe after release");
    pwr_good = 1'b0; btn_n = 1'b0; settle();
    check(exp_st, "R11 no force without main power");
    pwr_good = 1'b1; legacy_en = 1'b0; settle();
    check(exp_st, "R11 no force when mode off");
    legacy_en = 1'b1; ext_b = 1'b1; lvl3 = 1'b1; lvl5 = 1'b1; settle();
    exp_st = 2'b10;
    check(exp_st, "R11 force beats external pins");
    btn_n = 1'b1; settle(); exp_st = 2'b00;
    check(exp_st, "R8 pins resume after button release");

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule